// File: doc/BRIEF.md
# AUX Channel Reply Status Classifier

This block sits beside a DisplayPort AUX channel controller and watches its interrupt status flags while a command is outstanding. When a reply event arrives, it folds the flags into one error code, using one precedence scheme for native AUX transactions and another for I2C-over-AUX transactions. It then raises a one-cycle completion pulse. When the classified reply shows a PHY error, it also raises a request to clear the controller interrupts.

A failure counter tracks consecutive failed transfers. Every failure asks for a channel reset. Every fifth consecutive failure also asks for a PHY reconfiguration, and a successful transfer restarts the count. While an abort is in progress, transfers still complete and report their codes, but the count and the reset and reconfiguration requests are held back.

Top module: `aux_reply_classifier`

## Requirements
- R1: After reset, `err_code` is 0 and `done_pulse`, `clr_irq_req`, `chan_reset_req` and `reconfig_req` are all low.
- R2: Error codes on `err_code` are: 0 none, 1 wrong address, 2 timeout, 3 NACK, 4 defer, 5 NACK-defer, 6 PHY error. The code is updated only by a reply event and holds its value between events.
- R3: While `cmd_busy` is low, every status flag is ignored: no output pulses and `err_code` does not change.
- R4: Native mode (`native_mode`=1): done yields none; without done, wrong address yields address; without done or wrong address, timeout yields timeout. A set NACK-defer flag then overrides the result with NACK.
- R5: Native mode: a set PHY error flag overrides every other result with PHY error and raises `clr_irq_req` together with `done_pulse`.
- R6: I2C mode with done set: the result is NACK if the I2C NACK or the I2C defer flag is set, otherwise none. In this case the PHY error flag is not consulted and `clr_irq_req` stays low.
- R7: I2C mode without done: the overrides apply in rising precedence: address, timeout, NACK-defer (code 5), I2C NACK, I2C defer, PHY error. Each later one wins over the earlier ones.
- R8: I2C mode without done: a PHY error result raises `clr_irq_req` together with `done_pulse`.
- R9: Every reply event with a code other than none is a failure. Each failure raises `chan_reset_req` together with `done_pulse`.
- R10: `reconfig_req` pulses with the fifth, tenth and every later multiple-of-five consecutive failure.
- R11: A reply event with code none restarts the consecutive-failure count from zero.
- R12: While `abort` is high during a reply event, the code and `done_pulse` are still reported. The failure count does not change, and neither `chan_reset_req` nor `reconfig_req` is raised.
- R13: A reply event is a busy cycle with at least one flag relevant to the mode. In native mode, the I2C NACK and I2C defer flags alone do not make an event.
- R14: All results appear in the cycle after the clock edge that samples the event, and the pulses last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_busy | input | 1 | A command is outstanding; flags are honoured only when high |
| native_mode | input | 1 | 1 = native AUX transaction, 0 = I2C-over-AUX |
| abort | input | 1 | Suppresses failure counting and the reset and reconfiguration requests |
| st_done | input | 1 | Transfer-done status flag |
| st_wrong_addr | input | 1 | Wrong-address status flag |
| st_timeout | input | 1 | Reply-timeout status flag |
| st_nack_defer | input | 1 | Combined NACK/defer status flag |
| st_i2c_nack | input | 1 | I2C NACK status flag |
| st_i2c_defer | input | 1 | I2C defer status flag |
| st_phy_err | input | 1 | PHY/AUX error status flag |
| err_code | output | 3 | Classified error code (R2 encoding) |
| done_pulse | output | 1 | One-cycle completion pulse |
| clr_irq_req | output | 1 | One-cycle request to clear controller interrupts |
| chan_reset_req | output | 1 | One-cycle channel reset request on failure |
| reconfig_req | output | 1 | One-cycle PHY reconfiguration request |

## Verification
Every result of this block is due exactly one clock edge after the edge that samples the flags: the code, the completion pulse, the interrupt-clear request, and the reset and reconfiguration requests. The bench drives each event on a falling edge and reads all five outputs together on the next falling edge. One idle step follows to confirm that the pulses have fallen and the code is held. The count-dependent reconfiguration request is checked through runs of failures broken by successes and by aborted events, with the expected step worked out by hand.

// File: rtl/aux_rc_pkg.sv
package aux_rc_pkg;

  typedef enum logic [2:0] {
    RC_NONE       = 3'd0,
    RC_ADDR       = 3'd1,
    RC_TOUT       = 3'd2,
    RC_NACK       = 3'd3,
    RC_DEFER      = 3'd4,
    RC_NACK_DEFER = 3'd5,
    RC_PHY        = 3'd6
  } rc_code_e;

  typedef struct packed {
    logic phy_err;
    logic i2c_defer;
    logic i2c_nack;
    logic nack_defer;
    logic tout;
    logic wrong_addr;
    logic done;
  } rc_flags_t;

endpackage

// File: rtl/aux_rc_native_prio.sv
module aux_rc_native_prio
  import aux_rc_pkg::*;
(
  input  rc_flags_t flags,
  output rc_code_e  code,
  output logic      hit
);

  always_comb begin
    code = RC_NONE;
    if (flags.done)            code = RC_NONE;
    else if (flags.wrong_addr) code = RC_ADDR;
    else if (flags.tout)       code = RC_TOUT;
    if (flags.nack_defer)      code = RC_NACK;
    if (flags.phy_err)         code = RC_PHY;
  end

  assign hit = flags.done | flags.wrong_addr | flags.tout |
               flags.nack_defer | flags.phy_err;

endmodule

// File: rtl/aux_rc_i2c_prio.sv
module aux_rc_i2c_prio
  import aux_rc_pkg::*;
(
  input  rc_flags_t flags,
  output rc_code_e  code,
  output logic      hit
);

  always_comb begin
    code = RC_NONE;
    if (flags.done) begin
      code = (flags.i2c_nack | flags.i2c_defer) ? RC_NACK : RC_NONE;
    end else begin
      if (flags.wrong_addr) code = RC_ADDR;
      if (flags.tout)       code = RC_TOUT;
      if (flags.nack_defer) code = RC_NACK_DEFER;
      if (flags.i2c_nack)   code = RC_NACK;
      if (flags.i2c_defer)  code = RC_DEFER;
      if (flags.phy_err)    code = RC_PHY;
    end
  end

  assign hit = |flags;

endmodule

// File: rtl/aux_rc_retry.sv
module aux_rc_retry #(
  parameter int RECONFIG_EVERY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_ok,
  input  logic ev_fail,
  input  logic abort,
  output logic reset_req,
  output logic reconfig_req
);

  localparam int CW = (RECONFIG_EVERY > 1) ? $clog2(RECONFIG_EVERY) : 1;
  localparam logic [CW-1:0] LAST = CW'(RECONFIG_EVERY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          rst_d, rcfg_d;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    rst_d  = 1'b0;
    rcfg_d = 1'b0;
    if (!abort) begin
      if (ev_fail) begin
        cnt_en = 1'b1;
        rst_d  = 1'b1;
        if (cnt_q == LAST) begin
          cnt_d  = '0;
          rcfg_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (ev_ok) begin
        cnt_en = 1'b1;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      reset_req    <= 1'b0;
      reconfig_req <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      reset_req    <= rst_d;
      reconfig_req <= rcfg_d;
    end
  end

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R10
  rcfg_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_req |-> reset_req);

  // R11
  ok_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ok && !ev_fail && !abort) |=> (cnt_q == '0));

endmodule

// File: rtl/aux_reply_classifier.sv
module aux_reply_classifier
  import aux_rc_pkg::*;
#(
  parameter int RECONFIG_EVERY = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_busy,
  input  logic       native_mode,
  input  logic       abort,
  input  logic       st_done,
  input  logic       st_wrong_addr,
  input  logic       st_timeout,
  input  logic       st_nack_defer,
  input  logic       st_i2c_nack,
  input  logic       st_i2c_defer,
  input  logic       st_phy_err,
  output logic [2:0] err_code,
  output logic       done_pulse,
  output logic       clr_irq_req,
  output logic       chan_reset_req,
  output logic       reconfig_req
);

  rc_flags_t flags;
  rc_code_e  nat_code, i2c_code, sel_code;
  logic      nat_hit, i2c_hit, sel_hit;
  logic      ev, ev_fail, ev_ok;

  rc_code_e  code_q;
  logic      done_q, clr_q;
  logic      done_d, clr_d;

  assign flags = '{phy_err:    st_phy_err,
                   i2c_defer:  st_i2c_defer,
                   i2c_nack:   st_i2c_nack,
                   nack_defer: st_nack_defer,
                   tout:       st_timeout,
                   wrong_addr: st_wrong_addr,
                   done:       st_done};

  aux_rc_native_prio u_native (
    .flags (flags),
    .code  (nat_code),
    .hit   (nat_hit)
  );

  aux_rc_i2c_prio u_i2c (
    .flags (flags),
    .code  (i2c_code),
    .hit   (i2c_hit)
  );

  always_comb begin
    sel_code = native_mode ? nat_code : i2c_code;
    sel_hit  = native_mode ? nat_hit  : i2c_hit;
    ev       = cmd_busy & sel_hit;
    ev_fail  = ev & (sel_code != RC_NONE);
    ev_ok    = ev & (sel_code == RC_NONE);
    done_d   = ev;
    clr_d    = ev & (sel_code == RC_PHY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RC_NONE;
      done_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      if (ev) code_q <= sel_code;
      done_q <= done_d;
      clr_q  <= clr_d;
    end
  end

  aux_rc_retry #(.RECONFIG_EVERY(RECONFIG_EVERY)) u_retry (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_ok        (ev_ok),
    .ev_fail      (ev_fail),
    .abort        (abort),
    .reset_req    (chan_reset_req),
    .reconfig_req (reconfig_req)
  );

  assign err_code    = code_q;
  assign done_pulse  = done_q;
  assign clr_irq_req = clr_q;

  // R3
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_busy |=> (!done_pulse && $stable(err_code)));

  // R5
  clr_is_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_irq_req |-> (done_pulse && err_code == 3'd6));

  // R9
  reset_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_reset_req |-> (done_pulse && err_code != 3'd0));

  // R12
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!chan_reset_req && !reconfig_req));

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_code <= 3'd6);

endmodule

// File: tb/aux_reply_classifier_bench.sv
`timescale 1ns/1ps
module aux_reply_classifier_bench;

  localparam logic [6:0] F_DONE = 7'h01, F_ADDR = 7'h02, F_TOUT = 7'h04,
                         F_NKDF = 7'h08, F_INAK = 7'h10, F_IDEF = 7'h20,
                         F_PHY  = 7'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_busy = 1'b0, native_mode = 1'b0, abort = 1'b0;
  logic [6:0] fl = '0;
  logic [2:0] err_code;
  logic done_pulse, clr_irq_req, chan_reset_req, reconfig_req;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  aux_reply_classifier u_aux_reply_classifier (
    .clk(clk), .rst_n(rst_n), .cmd_busy(cmd_busy), .native_mode(native_mode),
    .abort(abort), .st_done(fl[0]), .st_wrong_addr(fl[1]), .st_timeout(fl[2]),
    .st_nack_defer(fl[3]), .st_i2c_nack(fl[4]), .st_i2c_defer(fl[5]),
    .st_phy_err(fl[6]), .err_code(err_code), .done_pulse(done_pulse),
    .clr_irq_req(clr_irq_req), .chan_reset_req(chan_reset_req),
    .reconfig_req(reconfig_req)
  );

  task automatic expect_out(input string req, input logic [2:0] code,
                            input logic d, input logic c, input logic r, input logic g);
    logic [6:0] act, exp;
    act = {err_code, done_pulse, clr_irq_req, chan_reset_req, reconfig_req};
    exp = {code, d, c, r, g};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {code,done,clr,rst,rcfg} actual=%b_%b expected=%b_%b",
               req, act[6:4], act[3:0], exp[6:4], exp[3:0]);
    end
  endtask

  // one cycle: drive at falling edge, result sampled at the next falling edge
  task automatic step(input logic nat, input logic busy, input logic ab, input logic [6:0] f);
    native_mode = nat; cmd_busy = busy; abort = ab; fl = f;
    @(negedge clk);
    cmd_busy = 1'b0; abort = 1'b0; fl = '0;
  endtask

  task automatic ok_native();
    step(1, 1, 0, F_DONE);
    expect_out("R11", 3'd0, 1, 0, 0, 0);
  endtask

  task automatic t_reset();
    expect_out("R1", 3'd0, 0, 0, 0, 0);
  endtask

  task automatic t_busy_gate();
    step(1, 0, 0, F_ADDR | F_PHY);
    expect_out("R3", 3'd0, 0, 0, 0, 0);
    step(0, 0, 0, F_IDEF);
    expect_out("R3", 3'd0, 0, 0, 0, 0);
  endtask

  task automatic t_native();
    ok_native();
    step(1, 1, 0, F_ADDR | F_TOUT);
    expect_out("R4", 3'd1, 1, 0, 1, 0);
    step(1, 1, 0, F_TOUT);
    expect_out("R4", 3'd2, 1, 0, 1, 0);
    step(1, 1, 0, F_DONE | F_NKDF);
    expect_out("R4", 3'd3, 1, 0, 1, 0);
    step(1, 1, 0, F_ADDR | F_NKDF);
    expect_out("R4", 3'd3, 1, 0, 1, 0);
    ok_native();
    step(1, 1, 0, F_PHY | F_DONE | F_NKDF);
    expect_out("R5", 3'd6, 1, 1, 1, 0);
    ok_native();
    step(1, 1, 0, F_INAK | F_IDEF);
    expect_out("R13", 3'd0, 0, 0, 0, 0);
  endtask

  task automatic t_i2c_done();
    step(0, 1, 0, F_DONE);
    expect_out("R6", 3'd0, 1, 0, 0, 0);
    step(0, 1, 0, F_DONE | F_INAK);
    expect_out("R6", 3'd3, 1, 0, 1, 0);
    step(0, 1, 0, F_DONE | F_IDEF);
    expect_out("R6", 3'd3, 1, 0, 1, 0);
    step(0, 1, 0, F_DONE | F_PHY);
    expect_out("R6", 3'd0, 1, 0, 0, 0);
  endtask

  task automatic t_i2c_order();
    step(0, 1, 0, F_ADDR);
    expect_out("R7", 3'd1, 1, 0, 1, 0);
    step(0, 1, 0, F_ADDR | F_TOUT);
    expect_out("R7", 3'd2, 1, 0, 1, 0);
    step(0, 1, 0, F_TOUT | F_NKDF);
    expect_out("R7", 3'd5, 1, 0, 1, 0);
    step(0, 1, 0, F_NKDF | F_INAK);
    expect_out("R7", 3'd3, 1, 0, 1, 0);
    step(0, 1, 0, F_INAK | F_IDEF);       // fifth consecutive failure
    expect_out("R7 R10", 3'd4, 1, 0, 1, 1);
    step(0, 1, 0, F_IDEF | F_PHY | F_ADDR);
    expect_out("R8", 3'd6, 1, 1, 1, 0);
    ok_native();
  endtask

  task automatic t_count();
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 0, F_TOUT);
      expect_out("R9", 3'd2, 1, 0, 1, 0);
    end
    ok_native();
    for (int i = 1; i <= 10; i++) begin
      step(1, 1, 0, F_TOUT);
      expect_out("R10", 3'd2, 1, 0, 1, (i % 5) == 0);
    end
  endtask

  task automatic t_abort();
    ok_native();
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 0, F_ADDR);
      expect_out("R12", 3'd1, 1, 0, 0 == 1 ? 0 : 1, 0);
    end
    step(0, 1, 1, F_TOUT);
    expect_out("R12", 3'd2, 1, 0, 0, 0);
    step(0, 1, 0, F_ADDR);
    expect_out("R12", 3'd1, 1, 0, 1, 1);
  endtask

  task automatic t_timing();
    step(1, 1, 0, F_PHY);
    expect_out("R14", 3'd6, 1, 1, 1, 0);
    step(1, 0, 0, '0);
    expect_out("R14", 3'd6, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_busy_gate();
    t_native();
    t_i2c_done();
    t_i2c_order();
    t_count();
    t_abort();
    t_timing();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule